// File: doc/BRIEF.md
# Grouped Two-Level Interrupt Controller

This block collects a wide bank of peripheral request inputs and hands the processor one interrupt vector at a time. The inputs are arranged as 12 groups of 8. Each input has a latched flag and a per-group enable bit. Each group has an acknowledge state that must be cleared before the group can forward another request. Each group drives one processor-level line, and that line is gated by a processor enable register and a global mask bit. Among all requests that pass every gate, a fixed two-level priority picks the winner. A lower group number always wins. Within a group, a lower input index wins.

When a request is taken, the block mimics what the processor does on interrupt entry. It sets the global mask, clears the taken group's processor enable bit and marks the group as awaiting acknowledge. It also pushes the global mask and enable register as they stood before entry onto a four-deep stack. A return strobe pops the stack and restores both values. Software can nest handlers by clearing the mask, re-enabling lines and acknowledging the group, which lets any pending enabled request preempt, including one from the same group. The block keeps no other record of being inside a handler.

Registers are reached through a single-cycle write port and a registered read port. Groups and inputs are numbered from zero, and input `irq_in[g*8+i]` is input `i` of group `g`.

Top module: `grpint_ctrl`

## Requirements
- R1: After reset, `take` and `stack_err` are 0. The global mask reads 1 (masked). The processor enable register, acknowledge register, group line register, all group enables and all flags read 0.
- R2: The flag for an input is set on a 0-to-1 transition of that input and can be read at address 0x20+g (bit i). An input held high after its flag has been cleared does not set the flag again.
- R3: A request is taken only when all of the following hold: its flag is set, its group enable bit is set, its group is not awaiting acknowledge, processor enable bit g (address 0x00) is set, and the global mask (address 0x01, bit 0) is 0.
- R4: When requests from several groups are eligible, the lowest-numbered group is served.
- R5: Within the served group, the lowest eligible input index is served.
- R6: A take raises `take` for exactly one cycle, on the clock edge after the edge at which the decision inputs were stable. In that same cycle `vec` = {group[3:0], index[2:0]}, and the served input's flag is cleared.
- R7: On a take, the global mask becomes 1 and processor enable bit g of the served group becomes 0.
- R8: On a take, the served group starts awaiting acknowledge, and bit g of address 0x02 reads 1. While it waits, the group forwards no request: its bit in the line register (0x03) is 0. Writing 1 to bit g of address 0x02 ends the wait.
- R9: A pulse on `ret_strobe` restores the global mask and the processor enable register from the most recent unreturned take, in last-in first-out order. With an empty stack, the pulse changes nothing.
- R10: After software clears the global mask and re-enables a line, a pending eligible request is taken even while an earlier one is still being served. This includes a request from the same group once that group has been acknowledged.
- R11: The stack holds 4 entries. A fifth take without a return sets `stack_err`, and `stack_err` stays set until reset.
- R12: No take is made in a cycle where `wr_en` or `ret_strobe` is high. A write in the same cycle as `ret_strobe` is dropped.
- R13: `rd_data` shows the register at `rd_addr` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 96 | Request inputs, group g input i at bit g*8+i |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 12 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 12 | Registered read data |
| ret_strobe | input | 1 | Return from service: pop and restore |
| take | output | 1 | One-cycle strobe, a vector is taken |
| vec | output | 7 | Taken vector {group, index} |
| stack_err | output | 1 | Sticky nesting stack overflow |

## Verification
The assertions assume that request inputs are already synchronous to `clk`. They also assume that software never changes an enable or the mask in the cycle a take is decided, which the block itself guarantees by holding off takes during writes and returns. The bench drives inputs only on falling edges. It raises requests only while the global mask is set, so the latched flag pattern is known before it clears the mask, and it draws the random enable registers and request patterns from a fixed seed. The nesting, acknowledge and overflow scenarios are directed, and their expected vectors and restored register values are worked out by hand.

// File: rtl/grpint_pkg.sv
package grpint_pkg;
    localparam int GRP_W = 4;
    localparam int IDX_W = 3;
    localparam int VEC_W = GRP_W + IDX_W;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic [IDX_W-1:0] idx;
    } vec_t;

    localparam int ADDR_CPU_EN    = 'h00;
    localparam int ADDR_GMASK     = 'h01;
    localparam int ADDR_ACK       = 'h02;
    localparam int ADDR_LINES     = 'h03;
    localparam int ADDR_GEN_BASE  = 'h10;
    localparam int ADDR_FLAG_BASE = 'h20;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/grpint_group.sv
module grpint_group #(
    parameter int NIDX = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NIDX-1:0] irq,
    input  logic            en_we,
    input  logic [NIDX-1:0] en_wdata,
    input  logic [NIDX-1:0] clr,
    output logic [NIDX-1:0] flags,
    output logic [NIDX-1:0] en,
    output logic            req
);
    logic [NIDX-1:0] irq_q;
    logic [NIDX-1:0] rise;

    assign rise = irq & ~irq_q;
    assign req  = |(flags & en);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            flags <= '0;
            en    <= '0;
        end else begin
            irq_q <= irq;
            flags <= (flags & ~clr) | rise;
            if (en_we) en <= en_wdata;
        end
    end

    // R6: a clear hits exactly one flag that was pending and enabled
    assert_clr_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));
    assert_clr_pending_R6: assert property (@(posedge clk) disable iff (rst)
        (|clr) |-> (|(clr & flags & en)));
endmodule

// File: rtl/grpint_arb.sv
module grpint_arb
    import grpint_pkg::*;
#(
    parameter int NGRP = 12,
    parameter int NIDX = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NGRP-1:0]      line,
    input  logic [NGRP-1:0]      cpu_en,
    input  logic                 gmask,
    input  logic                 hold,
    input  logic [NGRP*NIDX-1:0] pend,
    output logic                 valid,
    output vec_t                 vsel,
    output logic [NGRP-1:0]      grant
);
    logic [NGRP-1:0] elig;
    int              gsel;

    assign elig = line & cpu_en & {NGRP{~gmask & ~hold}};

    always_comb begin
        valid = 1'b0;
        gsel  = 0;
        grant = '0;
        for (int g = NGRP - 1; g >= 0; g--) begin
            if (elig[g]) begin
                valid = 1'b1;
                gsel  = g;
            end
        end
        if (valid) grant[gsel] = 1'b1;
        vsel.grp = GRP_W'(gsel);
        vsel.idx = '0;
        for (int i = NIDX - 1; i >= 0; i--) begin
            if (pend[gsel*NIDX + i]) vsel.idx = IDX_W'(i);
        end
    end

    // R4: at most one group granted
    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R3: the winner's line and processor enable were both up
    assert_grant_gated_R3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (line[vsel.grp] && cpu_en[vsel.grp] && !gmask));
endmodule

// File: rtl/grpint_stack.sv
module grpint_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic          full;
    logic [IW-1:0] top_ptr;
    logic [IW-1:0] wr_ptr;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_ptr = IW'(cnt - CW'(1));
    assign wr_ptr  = IW'(cnt);
    assign top     = empty ? '0 : mem[top_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            err <= 1'b0;
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (push) begin
            if (full) begin
                err <= 1'b1;
            end else begin
                mem[wr_ptr] <= din;
                cnt         <= cnt + CW'(1);
            end
        end else if (pop && !empty) begin
            cnt <= cnt - CW'(1);
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> err);
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

// File: rtl/grpint_ctrl.sv
module grpint_ctrl
    import grpint_pkg::*;
#(
    parameter int NGRP  = 12,
    parameter int NIDX  = 8,
    parameter int DEPTH = 4,
    parameter int AW    = 6,
    parameter int DW    = max_int(NGRP, NIDX)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NGRP*NIDX-1:0] irq_in,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data,
    input  logic                 ret_strobe,
    output logic                 take,
    output logic [VEC_W-1:0]     vec,
    output logic                 stack_err
);
    localparam int CTX_W = NGRP + 1;

    logic                 gmask_q;
    logic [NGRP-1:0]      cpu_en_q;
    logic [NGRP-1:0]      ack_q;
    logic                 take_q;
    vec_t                 vec_q;

    logic [NIDX-1:0]      flags [NGRP];
    logic [NIDX-1:0]      gen   [NGRP];
    logic [NGRP-1:0]      grp_req;
    logic [NGRP-1:0]      cpu_line;
    logic [NGRP*NIDX-1:0] pend;

    logic                 take_now;
    vec_t                 arb_vec;
    logic [NGRP-1:0]      grant;
    logic                 wr_ok;
    logic                 pop_ok;
    logic [CTX_W-1:0]     stk_top;
    logic                 stk_empty;
    logic [DW-1:0]        rd_next;

    assign wr_ok    = wr_en && !ret_strobe;
    assign cpu_line = grp_req & ~ack_q;
    assign pop_ok   = ret_strobe && !stk_empty;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [NIDX-1:0] clr;
        logic            en_we;
        assign clr   = grant[g] ? (NIDX'(1) << arb_vec.idx) : '0;
        assign en_we = wr_ok && (wr_addr == AW'(ADDR_GEN_BASE + g));

        grpint_group #(.NIDX(NIDX)) u_grp (
            .clk      (clk),
            .rst      (rst),
            .irq      (irq_in[g*NIDX +: NIDX]),
            .en_we    (en_we),
            .en_wdata (wr_data[NIDX-1:0]),
            .clr      (clr),
            .flags    (flags[g]),
            .en       (gen[g]),
            .req      (grp_req[g])
        );
        assign pend[g*NIDX +: NIDX] = flags[g] & gen[g];
    end

    grpint_arb #(.NGRP(NGRP), .NIDX(NIDX)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .line   (cpu_line),
        .cpu_en (cpu_en_q),
        .gmask  (gmask_q),
        .hold   (wr_en || ret_strobe),
        .pend   (pend),
        .valid  (take_now),
        .vsel   (arb_vec),
        .grant  (grant)
    );

    grpint_stack #(.DEPTH(DEPTH), .W(CTX_W)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (take_now),
        .pop   (pop_ok),
        .din   ({gmask_q, cpu_en_q}),
        .top   (stk_top),
        .empty (stk_empty),
        .err   (stack_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gmask_q  <= 1'b1;
            cpu_en_q <= '0;
            ack_q    <= '0;
            take_q   <= 1'b0;
            vec_q    <= '0;
        end else begin
            take_q <= take_now;
            if (take_now) begin
                vec_q    <= arb_vec;
                gmask_q  <= 1'b1;
                cpu_en_q <= cpu_en_q & ~grant;
                ack_q    <= ack_q | grant;
            end else if (pop_ok) begin
                {gmask_q, cpu_en_q} <= stk_top;
            end else if (wr_ok) begin
                if (wr_addr == AW'(ADDR_CPU_EN)) cpu_en_q <= wr_data[NGRP-1:0];
                if (wr_addr == AW'(ADDR_GMASK))  gmask_q  <= wr_data[0];
                if (wr_addr == AW'(ADDR_ACK))    ack_q    <= ack_q & ~wr_data[NGRP-1:0];
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (rd_addr == AW'(ADDR_CPU_EN)) rd_next = DW'(cpu_en_q);
        if (rd_addr == AW'(ADDR_GMASK))  rd_next = DW'(gmask_q);
        if (rd_addr == AW'(ADDR_ACK))    rd_next = DW'(ack_q);
        if (rd_addr == AW'(ADDR_LINES))  rd_next = DW'(cpu_line);
        for (int g = 0; g < NGRP; g++) begin
            if (rd_addr == AW'(ADDR_GEN_BASE + g))  rd_next = DW'(gen[g]);
            if (rd_addr == AW'(ADDR_FLAG_BASE + g)) rd_next = DW'(flags[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_next;
    end

    assign take = take_q;
    assign vec  = vec_q;

    assert_take_gate_R3: assert property (@(posedge clk) disable iff (rst)
        take_q |-> $past(!gmask_q));
    assert_take_hold_R12: assert property (@(posedge clk) disable iff (rst)
        take_q |-> $past(!wr_en && !ret_strobe));
    assert_single_take_R6: assert property (@(posedge clk) disable iff (rst)
        take_q |=> !take_q);
    assert_vec_range_R6: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (int'(vec_q.grp) < NGRP && int'(vec_q.idx) < NIDX));
    assert_entry_mask_R7: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (gmask_q && !cpu_en_q[vec_q.grp]));
    assert_entry_ack_R8: assert property (@(posedge clk) disable iff (rst)
        take_q |-> ack_q[vec_q.grp]);
    assert_ret_restore_R9: assert property (@(posedge clk) disable iff (rst)
        (ret_strobe && !stk_empty) |=> ({gmask_q, cpu_en_q} == $past(stk_top)));
endmodule

// File: tb/grpint_ctrl_tb.sv
module grpint_ctrl_tb;
    localparam int NG = 12;
    localparam int NI = 8;
    localparam logic [5:0] A_CEN = 6'h00, A_GM = 6'h01, A_ACK = 6'h02, A_LN = 6'h03;
    localparam logic [5:0] A_GEN = 6'h10, A_FLG = 6'h20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NG*NI-1:0] irq_in = '0;
    logic             wr_en = 1'b0;
    logic [5:0]       wr_addr = '0;
    logic [11:0]      wr_data = '0;
    logic [5:0]       rd_addr = '0;
    logic [11:0]      rd_data;
    logic             ret_strobe = 1'b0;
    logic             take;
    logic [6:0]       vec;
    logic             stack_err;

    int checks = 0;
    int errors = 0;
    int take_cnt = 0;
    logic [6:0] last_vec = '0;

    grpint_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ret_strobe(ret_strobe), .take(take), .vec(vec), .stack_err(stack_err)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (take) begin
            take_cnt = take_cnt + 1;
            last_vec = vec;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; irq_in = '0; wr_en = 1'b0; ret_strobe = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic wr(input logic [5:0] a, input logic [11:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [11:0] v);
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [11:0] e, input string tag);
        logic [11:0] v;
        rd(a, v);
        chk(v == e, tag, int'(v), int'(e));
    endtask

    task automatic pulse_irq(input logic [NG*NI-1:0] m);
        irq_in = irq_in | m;
        @(negedge clk);
        irq_in = irq_in & ~m;
    endtask

    task automatic ret_pulse();
        ret_strobe = 1'b1;
        @(negedge clk);
        ret_strobe = 1'b0;
    endtask

    // release mask, expect exactly one take with the given vector
    task automatic expect_take(input int g, input int i, input string tag);
        int n0;
        n0 = take_cnt;
        wr(A_GM, 12'h000);
        tick(3);
        chk(take_cnt == n0 + 1, {tag, " take count"}, take_cnt - n0, 1);
        chk(last_vec == {4'(g), 3'(i)}, {tag, " vector"}, int'(last_vec), int'({4'(g), 3'(i)}));
    endtask

    function automatic logic [NG*NI-1:0] bit_at(input int g, input int i);
        logic [NG*NI-1:0] r;
        r = '0;
        r[g*NI + i] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] exp_pick(input logic [NG*NI-1:0] m,
                                            input logic [NG*NI-1:0] ge,
                                            input logic [NG-1:0] ce);
        for (int g = 0; g < NG; g++)
            if (ce[g])
                for (int i = 0; i < NI; i++)
                    if (m[g*NI+i] && ge[g*NI+i]) return {1'b1, 4'(g), 3'(i)};
        return 8'h00;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] v;
        int n0;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        chk(take == 1'b0, "R1 take", int'(take), 0);
        chk(stack_err == 1'b0, "R1 stack_err", int'(stack_err), 0);
        rd_chk(A_GM,  12'h001, "R1 gmask");
        rd_chk(A_CEN, 12'h000, "R1 cpu_en");
        rd_chk(A_ACK, 12'h000, "R1 ack");
        rd_chk(A_LN,  12'h000, "R1 lines");
        rd_chk(A_GEN + 6'd3, 12'h000, "R1 group enable");

        // R2..R8 priority and entry
        wr(A_CEN, 12'hFFF);
        wr(A_GEN + 6'd1, 12'h0FF);
        wr(A_GEN + 6'd4, 12'h0FF);
        n0 = take_cnt;
        pulse_irq(bit_at(1,3) | bit_at(1,5) | bit_at(4,0));
        tick(1);
        rd_chk(A_FLG + 6'd1, 12'h028, "R2 flags latched");
        tick(3);
        chk(take_cnt == n0, "R3 masked no take", take_cnt - n0, 0);
        wr(A_GM, 12'h000);
        chk(take == 1'b0, "R6 take latency early", int'(take), 0);
        tick(1);
        chk(take == 1'b1, "R6 take strobe", int'(take), 1);
        chk(vec == {4'd1, 3'd3}, "R4 R5 vector", int'(vec), int'({4'd1, 3'd3}));
        tick(1);
        chk(take == 1'b0, "R6 single cycle", int'(take), 0);
        n0 = take_cnt;
        tick(3);
        chk(take_cnt == n0, "R7 no take after entry", take_cnt - n0, 0);
        rd_chk(A_GM,  12'h001, "R7 gmask set");
        rd_chk(A_CEN, 12'hFFD, "R7 cpu_en bit cleared");
        rd_chk(A_ACK, 12'h002, "R8 ack pending");
        rd_chk(A_FLG + 6'd1, 12'h020, "R6 flag cleared");
        rd_chk(A_LN,  12'h010, "R8 group line blocked");

        // R10 nesting, R8 acknowledge gating
        wr(A_CEN, 12'h812);
        expect_take(4, 0, "R10 R8 preempt other group");
        rd_chk(A_ACK, 12'h012, "R8 two pending");
        wr(A_ACK, 12'h002);
        rd_chk(A_ACK, 12'h010, "R8 ack write clears");
        n0 = take_cnt;
        tick(3);
        chk(take_cnt == n0, "R3 mask still set", take_cnt - n0, 0);
        wr(A_CEN, 12'h0F3);
        expect_take(1, 5, "R10 same group preempt");

        // R9 restore in LIFO order
        ret_pulse();
        rd_chk(A_CEN, 12'h0F3, "R9 pop3 cpu_en");
        rd_chk(A_GM,  12'h000, "R9 pop3 gmask");
        ret_pulse();
        rd_chk(A_CEN, 12'h812, "R9 pop2 cpu_en");
        ret_pulse();
        rd_chk(A_CEN, 12'hFFF, "R9 pop1 cpu_en");
        rd_chk(A_GM,  12'h000, "R9 pop1 gmask");
        ret_pulse();
        rd_chk(A_CEN, 12'hFFF, "R9 empty pop no change");
        chk(stack_err == 1'b0, "R11 no overflow yet", int'(stack_err), 0);

        // R12 takes held off during writes
        wr(A_GM, 12'h001);
        wr(A_GEN + 6'd2, 12'h010);
        pulse_irq(bit_at(2,4));
        n0 = take_cnt;
        wr_en = 1'b1; wr_addr = A_GM; wr_data = 12'h000;
        @(negedge clk);
        wr_addr = A_GEN + 6'd7; wr_data = 12'h000;
        @(negedge clk);
        chk(take_cnt == n0, "R12 held by write 1", take_cnt - n0, 0);
        @(negedge clk);
        chk(take_cnt == n0, "R12 held by write 2", take_cnt - n0, 0);
        wr_en = 1'b0;
        @(negedge clk);
        chk(take == 1'b1 && vec == {4'd2, 3'd4}, "R12 take after write", int'(vec), int'({4'd2, 3'd4}));

        // R13 read latency
        rd(A_CEN, v);
        chk(v == 12'hFFB, "R13 read value", int'(v), 'hFFB);
        rd_addr = A_GM;
        #1;
        chk(rd_data == 12'hFFB, "R13 old value before edge", int'(rd_data), 'hFFB);
        @(negedge clk);
        chk(rd_data == 12'h001, "R13 new value after edge", int'(rd_data), 1);

        // R11 overflow and R2 held level
        do_reset();
        wr(A_CEN, 12'hFFF);
        for (int g = 0; g < 6; g++) wr(A_GEN + 6'(g), 12'h001);
        for (int g = 0; g < 6; g++) irq_in = irq_in | bit_at(g, 0);
        tick(1);
        for (int k = 0; k < 5; k++) begin
            expect_take(k, 0, "R11 nested take");
            chk(stack_err == (k == 4), "R11 stack_err", int'(stack_err), int'(k == 4));
        end
        rd_chk(A_FLG + 6'd0, 12'h000, "R2 held level no relatch");
        for (int k = 0; k < 4; k++) ret_pulse();
        chk(stack_err == 1'b1, "R11 sticky", int'(stack_err), 1);
        irq_in = '0;

        // R3 R4 R5 random patterns against bench model
        for (int t = 0; t < 16; t++) begin
            logic [NG*NI-1:0] m;
            logic [NG*NI-1:0] ge;
            logic [NG-1:0]    ce;
            logic [7:0]       e;
            do_reset();
            ce = NG'($urandom);
            wr(A_CEN, ce);
            for (int g = 0; g < NG; g++) begin
                ge[g*NI +: NI] = NI'($urandom);
                wr(A_GEN + 6'(g), 12'(ge[g*NI +: NI]));
            end
            for (int b = 0; b < NG*NI; b++) m[b] = ($urandom % 10) == 0;
            pulse_irq(m);
            e = exp_pick(m, ge, ce);
            n0 = take_cnt;
            wr(A_GM, 12'h000);
            tick(3);
            if (e[7]) begin
                chk(take_cnt == n0 + 1, "R3 random take count", take_cnt - n0, 1);
                chk(last_vec == e[6:0], "R4 R5 random vector", int'(last_vec), int'(e[6:0]));
            end else begin
                chk(take_cnt == n0, "R3 random no eligible", take_cnt - n0, 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule